// File: doc/BRIEF.md
# Asynchronous Host Port for a Shared Word Buffer

This block lets an external host, whose strobes bear no timing relation to the local clock, read and write a shared buffer of 2048 sixteen-bit words. The buffer lives in the controller's clock domain (the microtick clock). The host's active-low chip enable, write enable and output enable are brought into that domain through two-flop synchronisers. A falling chip enable is detected on the synchronised copy. It captures the address, the write data and the write flag. The block then runs one memory operation and answers on an active-low ready line.

A second, fully synchronous port serves the internal protocol engine. It takes a plain enable and write flag and returns registered read data. Each host read lands in a hold register. The host's output enable only gates that stored value onto the bus; it never starts a memory access. The host data bus is modelled as a data-out vector plus a drive flag. When both ports write the same word in the same clock, the internal port wins.

Top module: `shb_host_port`

## Requirements
- R1: The host port addresses 2048 words with an 11-bit address and moves 16-bit data; a word written by the host at any address, including 0 and 2047, reads back unchanged through the host port.
- R2: All three host controls pass through two-flop synchronisers. Call edge 0 the first rising clock edge that samples host_cs_n low after it was sampled high. The access starts at edge 2, which captures host_addr, host_wdata and the synchronised host_we_n level (0 = write, 1 = read).
- R3: Changes of host_addr and host_wdata after the start edge have no effect on the access in progress.
- R4: The memory operation takes place at edge 3. host_rdy_n (0 = done) goes low after edge 4, five clocks after the strobe, so inside the six-clock read limit. Let edge m be the first edge that samples host_cs_n high again. host_rdy_n returns high after edge m+2.
- R5: A host read loads the word into a hold register at edge 4. Only a completed host read changes the hold register; writes leave it alone.
- R6: host_rdata always presents the hold register. host_rdata_en is 1 after the second edge that samples host_oe_n low and host_we_n high, and 0 otherwise. Output enable with chip enable high starts no access and leaves host_rdy_n high.
- R7: The internal port writes core_wdata when core_en=1 and core_we=1. It reads when core_en=1 and core_we=0, and the word appears on core_rdata after that edge. core_rdata keeps its value otherwise. A host read at the same edge as an internal write to the same word returns the previous contents.
- R8: When the host write edge (edge 3) and an internal write hit the same address at the same edge, the internal data is stored and the host write is dropped.
- R9: After synchronous reset (rst_n low): host_rdy_n=1, host_rdata_en=0, host_rdata=0, core_rdata=0.
- R10: Chip enable held low after completion starts no second access. host_rdy_n stays low and the hold register keeps its value until chip enable is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microtick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs_n | input | 1 | Host chip enable, active low, asynchronous |
| host_we_n | input | 1 | Host write enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_addr | input | 11 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Hold register (last host read) |
| host_rdata_en | output | 1 | Host bus drive flag |
| host_rdy_n | output | 1 | Access finished, active low |
| core_en | input | 1 | Internal port enable |
| core_we | input | 1 | Internal port write flag |
| core_addr | input | 11 | Internal port word address |
| core_wdata | input | 16 | Internal port write data |
| core_rdata | output | 16 | Internal port read data |

## Verification
The host port's memory edge and an internal-port write can land on the same clock. The bench provokes this by raising an internal write three clocks after it drops chip enable, so that it meets edge 3 of the host access. It does this once with a host write to the same word and once with a host read of it. A behavioural reference model, advanced every clock, predicts the stored word and the returned data for both cases. Read-backs through both ports then confirm that the internal data won, and that the concurrent host read saw the old contents.

// File: rtl/shb_pkg.sv
// Shared types and default sizes for the host shared-buffer port.
// Assumes: one clock domain (microtick) for everything inside the block.
package shb_pkg;
    localparam int unsigned SHB_AW = 11;
    localparam int unsigned SHB_DW = 16;

    // Host access sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // waiting for synchronised chip-enable fall
        SQ_ACC  = 2'd1,   // memory operation on this edge
        SQ_LAT  = 2'd2,   // read word moves into hold register
        SQ_DONE = 2'd3    // ready asserted until chip enable released
    } seq_state_t;
endpackage

// File: rtl/shb_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes: each bit is sampled on its own; no bus coherency is implied.
// Reset drives every stage to RST_VAL (inactive level for active-low strobes).
module shb_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two sampling stages per bit
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q[gi] <= RST_VAL[gi];
                    stab_q[gi] <= RST_VAL[gi];
                end else begin
                    meta_q[gi] <= d_async[gi];
                    stab_q[gi] <= meta_q[gi];
                end
            end
        end
    endgenerate

    assign q_sync = stab_q;
endmodule

// File: rtl/shb_dpram.sv
// Two-port word memory: port A for the host sequencer, port B for the core.
// Both ports read synchronously (one-edge latency, old data on a same-edge
// write) and keep their read register when not reading.
// Assumes: when both ports write one word on one edge, port B wins.
module shb_dpram #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          b_wr;
    logic          a_wr;
    logic          clash;

    assign b_wr  = b_en && b_we;
    assign clash = b_wr && (b_addr == a_addr);
    assign a_wr  = a_en && a_we && !clash;

    // Array writes, core port has priority on a shared address
    always_ff @(posedge clk) begin
        if (b_wr) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_wr) begin
            mem[a_addr] <= a_wdata;
        end
    end

    // Host-side read register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
        end else if (a_en && !a_we) begin
            a_rdata <= mem[a_addr];
        end
    end

    // Core-side read register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rdata <= '0;
        end else if (b_en && !b_we) begin
            b_rdata <= mem[b_addr];
        end
    end

    // R8
    collide_core_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we && (a_addr == b_addr))
        |=> (mem[$past(b_addr)] == $past(b_wdata)));
endmodule

// File: rtl/shb_host_seq.sv
// Host access sequencer. Detects the fall of the synchronised chip enable,
// captures address, data and write flag, runs one operation on the memory's
// host port, stores read results and holds ready low until chip enable is
// seen released.
// Assumes: address, data and write enable are stable from before the chip
// enable fall until at least the capture edge.
module shb_host_seq
    import shb_pkg::*;
#(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          we_s,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] hold_q,
    output logic          rdy_n
);
    seq_state_t    state_q;
    seq_state_t    state_d;
    logic          cs_prev_q;
    logic          start;
    logic [AW-1:0] cap_addr_q;
    logic [DW-1:0] cap_data_q;
    logic          cap_wr_q;

    assign start = (state_q == SQ_IDLE) && !cs_s && cs_prev_q;

    // Delayed copy of synchronised chip enable for fall detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q <= 1'b1;
        end else begin
            cs_prev_q <= cs_s;
        end
    end

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (start) state_d = SQ_ACC;
            SQ_ACC:  state_d = SQ_LAT;
            SQ_LAT:  state_d = SQ_DONE;
            SQ_DONE: if (cs_s) state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture of the host request at the start edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_q <= '0;
            cap_data_q <= '0;
            cap_wr_q   <= 1'b0;
        end else if (start) begin
            cap_addr_q <= host_addr;
            cap_data_q <= host_wdata;
            cap_wr_q   <= !we_s;
        end
    end

    // Hold register for the last completed host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if ((state_q == SQ_LAT) && !cap_wr_q) begin
            hold_q <= mem_rdata;
        end
    end

    assign mem_en    = (state_q == SQ_ACC);
    assign mem_we    = cap_wr_q;
    assign mem_addr  = cap_addr_q;
    assign mem_wdata = cap_data_q;
    assign rdy_n     = (state_q != SQ_DONE);

    // R4
    ready_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> ($past(state_q, 3) == SQ_IDLE));

    // R5
    hold_on_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_q) |-> $fell(rdy_n));

    // R10
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SQ_DONE) && !cs_s) |=> (state_q == SQ_DONE));
endmodule

// File: rtl/shb_host_port.sv
// Top of the host shared-buffer port. Synchronises the host strobes,
// sequences host accesses onto a two-port memory and exposes a synchronous
// port for the core. The host data bus is split into a data vector and a
// drive flag; the flag follows the synchronised output and write enables.
// Assumes: host timing minimums (chip enable 2 clocks, address/data/write
// enable 3 clocks) are met; the bench or pad ring builds the tristate.
module shb_host_port
    import shb_pkg::*;
#(
    parameter int unsigned AW = SHB_AW,
    parameter int unsigned DW = SHB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs_n,
    input  logic          host_we_n,
    input  logic          host_oe_n,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdata_en,
    output logic          host_rdy_n,
    input  logic          core_en,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic [DW-1:0] core_rdata
);
    localparam int unsigned NSTROBE = 3;

    logic [NSTROBE-1:0] strobe_raw;
    logic [NSTROBE-1:0] strobe_s;
    logic               cs_s;
    logic               we_s;
    logic               oe_s;
    logic               a_en;
    logic               a_we;
    logic [AW-1:0]      a_addr;
    logic [DW-1:0]      a_wdata;
    logic [DW-1:0]      a_rdata;

    assign strobe_raw = {host_oe_n, host_we_n, host_cs_n};

    shb_sync #(
        .W       (NSTROBE),
        .RST_VAL ({NSTROBE{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (strobe_raw),
        .q_sync  (strobe_s)
    );

    assign cs_s = strobe_s[0];
    assign we_s = strobe_s[1];
    assign oe_s = strobe_s[2];

    shb_host_seq #(
        .AW (AW),
        .DW (DW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .we_s       (we_s),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_en     (a_en),
        .mem_we     (a_we),
        .mem_addr   (a_addr),
        .mem_wdata  (a_wdata),
        .mem_rdata  (a_rdata),
        .hold_q     (host_rdata),
        .rdy_n      (host_rdy_n)
    );

    shb_dpram #(
        .AW (AW),
        .DW (DW)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_en    (core_en),
        .b_we    (core_we),
        .b_addr  (core_addr),
        .b_wdata (core_wdata),
        .b_rdata (core_rdata)
    );

    // Drive flag: synchronised output enable during a read cycle only
    assign host_rdata_en = !oe_s && we_s;
endmodule

// File: tb/sim_shb_host_port.sv
module sim_shb_host_port;
    localparam int AW = 11;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_cs_n = 1'b1;
    logic          host_we_n = 1'b1;
    logic          host_oe_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdata_en;
    logic          host_rdy_n;
    logic          core_en = 1'b0;
    logic          core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [DW-1:0] core_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #4 clk = ~clk;

    shb_host_port #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_cs_n(host_cs_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_en(host_rdata_en), .host_rdy_n(host_rdy_n),
        .core_en(core_en), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata)
    );

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] mm [0:(1<<AW)-1];
    logic cs_h1, cs_h2, cs_h3, we_h1, we_h2, oe_h1;
    int   ph;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_data;
    logic c_wr;
    logic [DW-1:0] rd_tmp;
    logic m_rdy_n, m_drive;
    logic [DW-1:0] m_hold, m_crd;

    initial begin
        for (int i = 0; i < (1 << AW); i++) mm[i] = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cs_h1 = 1; cs_h2 = 1; cs_h3 = 1; we_h1 = 1; we_h2 = 1; oe_h1 = 1;
            ph = 0; m_rdy_n = 1; m_drive = 0; m_hold = '0; m_crd = '0;
        end else begin
            logic [DW-1:0] snap_core;
            logic [DW-1:0] snap_host;
            logic hw;
            snap_core = mm[core_addr];
            hw = 0;
            case (ph)
                0: if (!cs_h2 && cs_h3) begin
                       c_addr = host_addr; c_data = host_wdata; c_wr = !we_h2; ph = 1;
                   end
                1: begin
                       snap_host = mm[c_addr];
                       if (!c_wr) rd_tmp = snap_host;
                       else hw = !(core_en && core_we && core_addr == c_addr);
                       ph = 2;
                   end
                2: begin
                       if (!c_wr) m_hold = rd_tmp;
                       m_rdy_n = 0; ph = 3;
                   end
                default: if (cs_h2) begin m_rdy_n = 1; ph = 0; end
            endcase
            if (core_en && !core_we) m_crd = snap_core;
            if (core_en && core_we) mm[core_addr] = core_wdata;
            if (hw) mm[c_addr] = c_data;
            m_drive = !oe_h1 && we_h1;
            cs_h3 = cs_h2; cs_h2 = cs_h1; cs_h1 = host_cs_n;
            we_h2 = we_h1; we_h1 = host_we_n;
            oe_h1 = host_oe_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk("R4 ready", {31'b0, host_rdy_n}, {31'b0, m_rdy_n});
            chk("R6 drive", {31'b0, host_rdata_en}, {31'b0, m_drive});
            chk("R5 hold", {16'b0, host_rdata}, {16'b0, m_hold});
            chk("R7 core rdata", {16'b0, core_rdata}, {16'b0, m_crd});
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    int lat;

    // host access: returns cycles from chip-enable fall to ready seen low
    task automatic host_acc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit wr, input int extra);
        int cnt;
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we_n = !wr;
        @(negedge clk);
        host_cs_n = 0;
        cnt = 0;
        while (host_rdy_n && cnt < 50) begin @(negedge clk); cnt++; end
        lat = cnt;
        repeat (extra) @(negedge clk);
        host_cs_n = 1;
        cnt = 0;
        while (!host_rdy_n && cnt < 50) begin @(negedge clk); cnt++; end
        host_we_n = 1;
    endtask

    task automatic host_rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        host_acc(a, '0, 0, 0);
        host_oe_n = 0;
        repeat (3) @(negedge clk);
        chk({tag, " bus drive"}, {31'b0, host_rdata_en}, 32'd1);
        chk({tag, " bus data"}, {16'b0, host_rdata}, {16'b0, exp});
        host_oe_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic core_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        core_en = 1; core_we = 1; core_addr = a; core_wdata = d;
        @(negedge clk);
        core_en = 0; core_we = 0;
    endtask

    task automatic core_rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        core_en = 1; core_we = 0; core_addr = a;
        @(negedge clk);
        core_en = 0;
        chk(tag, {16'b0, core_rdata}, {16'b0, exp});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 rdy_n", {31'b0, host_rdy_n}, 32'd1);
        chk("R9 drive", {31'b0, host_rdata_en}, 32'd0);
        chk("R9 host_rdata", {16'b0, host_rdata}, 32'd0);
        chk("R9 core_rdata", {16'b0, core_rdata}, 32'd0);
        rst_n = 1;
        cmp_on = 1;
        repeat (3) @(negedge clk);

        // R1 / R2 / R4: writes and reads at both ends of the address space
        host_acc(11'd0, 16'hA5A5, 1, 0);
        chk("R2 R4 write latency", lat, 5);
        host_acc(11'd2047, 16'h5A3C, 1, 1);
        host_acc(11'd300, 16'h1234, 1, 0);
        host_rd_chk(11'd0, 16'hA5A5, "R1 addr0");
        chk("R4 read latency", lat, 5);
        host_rd_chk(11'd2047, 16'h5A3C, "R1 addr2047");
        host_rd_chk(11'd300, 16'h1234, "R1 addr300");

        // R5: a host write leaves the hold register alone
        host_acc(11'd5, 16'hBEEF, 1, 0);
        chk("R5 hold after write", {16'b0, host_rdata}, 32'h1234);

        // R6: output enable alone starts nothing
        host_oe_n = 0;
        repeat (6) @(negedge clk);
        chk("R6 oe no ready", {31'b0, host_rdy_n}, 32'd1);
        chk("R6 oe hold kept", {16'b0, host_rdata}, 32'h1234);
        host_oe_n = 1;
        repeat (3) @(negedge clk);
        // R6: output enable during a write cycle does not drive
        host_we_n = 0; host_oe_n = 0;
        repeat (4) @(negedge clk);
        chk("R6 no drive while writing", {31'b0, host_rdata_en}, 32'd0);
        host_we_n = 1; host_oe_n = 1;
        repeat (3) @(negedge clk);

        // R3: address changes after the start edge are ignored
        @(negedge clk);
        host_addr = 11'd5; host_we_n = 1;
        @(negedge clk);
        host_cs_n = 0;
        repeat (3) @(negedge clk);
        host_addr = 11'd300;
        while (host_rdy_n) @(negedge clk);
        chk("R3 captured address", {16'b0, host_rdata}, 32'hBEEF);
        // R10: long chip enable gives no second access
        repeat (10) @(negedge clk);
        chk("R10 ready held", {31'b0, host_rdy_n}, 32'd0);
        chk("R10 hold kept", {16'b0, host_rdata}, 32'hBEEF);
        host_cs_n = 1;
        repeat (4) @(negedge clk);
        chk("R4 ready released", {31'b0, host_rdy_n}, 32'd1);

        // R7: internal port write/read
        core_wr(11'd77, 16'h0F0F);
        core_rd_chk(11'd77, 16'h0F0F, "R7 core read");
        core_rd_chk(11'd2047, 16'h5A3C, "R7 core sees host word");
        host_rd_chk(11'd77, 16'h0F0F, "R7 host sees core word");

        // R8: same-edge write collision, core wins
        @(negedge clk);
        host_addr = 11'd400; host_wdata = 16'h1111; host_we_n = 0;
        @(negedge clk);
        host_cs_n = 0;
        repeat (3) @(negedge clk);
        core_en = 1; core_we = 1; core_addr = 11'd400; core_wdata = 16'h2222;
        @(negedge clk);
        core_en = 0; core_we = 0;
        while (host_rdy_n) @(negedge clk);
        host_cs_n = 1;
        while (!host_rdy_n) @(negedge clk);
        host_we_n = 1;
        core_rd_chk(11'd400, 16'h2222, "R8 core wins");
        host_rd_chk(11'd400, 16'h2222, "R8 host write dropped");

        // R7: host read meets internal write on the same edge -> old data
        @(negedge clk);
        host_addr = 11'd400; host_we_n = 1;
        @(negedge clk);
        host_cs_n = 0;
        repeat (3) @(negedge clk);
        core_en = 1; core_we = 1; core_addr = 11'd400; core_wdata = 16'h3333;
        @(negedge clk);
        core_en = 0; core_we = 0;
        while (host_rdy_n) @(negedge clk);
        chk("R7 host read old data", {16'b0, host_rdata}, 32'h2222);
        host_cs_n = 1;
        while (!host_rdy_n) @(negedge clk);
        core_rd_chk(11'd400, 16'h3333, "R7 core write landed");

        repeat (5) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule